// File: doc/BRIEF.md
# Fuzzy Cache Update Decision Unit

This block sits beside an automaton cache and decides, each time a cache candidate is visited, whether that entry is worth writing into the cache. It looks at two things. The first is how frequently the visit path has recurred, kept as a moving average of the gap between visits. The second is how far the reached state lies below the root. A small history table is addressed by visit path, not by state number. Each row remembers the visit count at the previous visit and the running average gap.

The average gap and the depth are each graded into three overlapping trapezoidal sets with programmable breakpoints. Every pairing of an interval set with a depth set carries one programmable yes/no bit. The firing strengths of the pairings marked yes are summed, and so are those of the pairings marked no. With yes and no as singletons at one and zero, the centroid rule reduces to a comparison of the two sums, so no divider is needed. A decision appears two clock edges after the visit.

Top module: `fuzzy_update_decider`

## Requirements
- R1: During reset the decision outputs are low, the visit counter is zero, and every history row holds zero for both the last count and the average.
- R2: The visit counter advances by one on each cycle with `stepEn` high and wraps modulo 2^CNT_W. The gap of a visit is (counter − row's last count) modulo 2^CNT_W, using the counter value before any increment in that cycle.
- R3: A visit replaces the row average with floor((avg·K + gap·(8−K))/8), where K = WEIGHT_K is the weight in eighths, and stores the counter as the new last count. A larger K therefore reacts more slowly to a new gap.
- R4: A visit changes only the row selected by `pathIdx`. Other paths keep their history.
- R5: The average gap is graded by ramp(x,s) = 0 for x<s, else min(255, ((x−s)·256)>>IV_RAMP_SH). Small = 255 − ramp(x,ivEdgeLo), large = ramp(x,ivEdgeHi), medium = min(ramp(x,ivEdgeLo), 255 − ramp(x,ivEdgeHi)).
- R6: The depth is graded the same way with dpEdgeLo, dpEdgeHi and DP_RAMP_SH into shallow, medium and deep.
- R7: Interval set i (0 small, 1 medium, 2 large) and depth set j (0 shallow, 1 medium, 2 deep) fire with strength min(interval degree, depth degree). Bit 3·i+j of `ruleTbl` marks that pairing yes (1) or no (0).
- R8: `decYes` is 1 only when the summed yes strength is strictly greater than the summed no strength.
- R9: A visit accepted at clock edge t raises `decValid` for exactly one cycle after edge t+1. `decYes` is low whenever `decValid` is low.
- R10: With an all-zero rule table every decision is no. With an all-ones rule table every decision is yes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | One matching iteration elapsed; advances the visit counter |
| visitValid | input | 1 | A visit to be judged is presented this cycle |
| pathIdx | input | PATH_W | Visit path selecting the history row |
| depthIn | input | DEPTH_W | Depth of the reached state below the root |
| ivEdgeLo | input | CNT_W | Start of the small-to-medium transition of the gap |
| ivEdgeHi | input | CNT_W | Start of the medium-to-large transition of the gap |
| dpEdgeLo | input | DEPTH_W | Start of the shallow-to-medium transition of the depth |
| dpEdgeHi | input | DEPTH_W | Start of the medium-to-deep transition of the depth |
| ruleTbl | input | 9 | Yes/no bit per interval-depth pairing, bit 3·i+j |
| decValid | output | 1 | Decision strobe |
| decYes | output | 1 | Write-into-cache decision |

## Verification
On every cycle the assertions check the decision timing, namely the two-edge latency and the single-cycle strobe. They also check that no yes escapes without a strobe and that the all-zero and all-ones rule tables force their outcomes. The arithmetic content of a decision cannot be seen by a property at the ports. Only the bench's scenarios show it: the moving average under a given weight, isolation between paths, the gap across a counter wrap, and the graded membership near the breakpoints. The bench follows each visit with an independent model of the average and the rule sums.

// File: rtl/fzd_pkg.sv
package fzd_pkg;
  localparam int DEG_W   = 8;
  localparam int SETS    = 3;
  localparam int RULES   = SETS * SETS;
  localparam int SUM_W   = DEG_W + 4;

  typedef struct packed {
    logic tblWrite;   // update the history row of the presented path
    logic stageLoad;  // capture average and depth for grading
    logic outLoad;    // register the decision
  } fzd_strobe_t;
endpackage

// File: rtl/fzd_member.sv
module fzd_member #(
  parameter int W  = 16,
  parameter int SH = 4
) (
  input  logic [W-1:0]                      x,
  input  logic [W-1:0]                      edgeLo,
  input  logic [W-1:0]                      edgeHi,
  output logic [fzd_pkg::SETS-1:0][fzd_pkg::DEG_W-1:0] deg
);
  import fzd_pkg::*;

  function automatic logic [DEG_W-1:0] ramp(input logic [W-1:0] v, input logic [W-1:0] s);
    logic [W+DEG_W-1:0] sc;
    if (v < s) return '0;
    sc = {v - s, {DEG_W{1'b0}}} >> SH;
    return (|sc[W+DEG_W-1:DEG_W]) ? {DEG_W{1'b1}} : sc[DEG_W-1:0];
  endfunction

  logic [DEG_W-1:0] upLo, upHi, downHi;

  always_comb begin
    upLo   = ramp(x, edgeLo);
    upHi   = ramp(x, edgeHi);
    downHi = {DEG_W{1'b1}} - upHi;
    deg[0] = {DEG_W{1'b1}} - upLo;
    deg[1] = (upLo < downHi) ? upLo : downHi;
    deg[2] = upHi;
  end
endmodule

// File: rtl/fzd_ctrl.sv
module fzd_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                visitValid,
  output fzd_pkg::fzd_strobe_t strobe,
  output logic                decValid
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      decValid   <= 1'b0;
    end else begin
      stageValid <= visitValid;
      decValid   <= stageValid;
    end
  end

  always_comb begin
    strobe.tblWrite  = visitValid;
    strobe.stageLoad = visitValid;
    strobe.outLoad   = stageValid;
  end
endmodule

// File: rtl/fzd_datapath.sv
module fzd_datapath #(
  parameter int PATHS      = 16,
  parameter int CNT_W      = 16,
  parameter int DEPTH_W    = 8,
  parameter int WEIGHT_K   = 4,
  parameter int IV_RAMP_SH = 4,
  parameter int DP_RAMP_SH = 2,
  localparam int PATH_W    = $clog2(PATHS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fzd_pkg::fzd_strobe_t strobe,
  input  logic                 stepEn,
  input  logic [PATH_W-1:0]    pathIdx,
  input  logic [DEPTH_W-1:0]   depthIn,
  input  logic [CNT_W-1:0]     ivEdgeLo,
  input  logic [CNT_W-1:0]     ivEdgeHi,
  input  logic [DEPTH_W-1:0]   dpEdgeLo,
  input  logic [DEPTH_W-1:0]   dpEdgeHi,
  input  logic [fzd_pkg::RULES-1:0] ruleTbl,
  output logic                 decYes
);
  import fzd_pkg::*;

  localparam int MIX_W = CNT_W + 4;
  localparam logic [MIX_W-1:0] KOLD = MIX_W'(WEIGHT_K);
  localparam logic [MIX_W-1:0] KNEW = MIX_W'(8 - WEIGHT_K);

  logic [CNT_W-1:0]   visitCnt;
  logic [CNT_W-1:0]   lastTbl [PATHS];
  logic [CNT_W-1:0]   avgTbl  [PATHS];
  logic [CNT_W-1:0]   gap, newAvg, avgQ;
  logic [MIX_W-1:0]   mix;
  logic [DEPTH_W-1:0] depthQ;

  // history update
  always_comb begin
    gap    = visitCnt - lastTbl[pathIdx];
    mix    = {4'b0, avgTbl[pathIdx]} * KOLD + {4'b0, gap} * KNEW;
    newAvg = CNT_W'(mix >> 3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      visitCnt <= '0;
      avgQ     <= '0;
      depthQ   <= '0;
      for (int p = 0; p < PATHS; p++) begin
        lastTbl[p] <= '0;
        avgTbl[p]  <= '0;
      end
    end else begin
      if (stepEn) visitCnt <= visitCnt + 1'b1;
      if (strobe.tblWrite) begin
        lastTbl[pathIdx] <= visitCnt;
        avgTbl[pathIdx]  <= newAvg;
      end
      if (strobe.stageLoad) begin
        avgQ   <= newAvg;
        depthQ <= depthIn;
      end
    end
  end

  // grading
  logic [SETS-1:0][DEG_W-1:0] ivDeg, dpDeg;

  fzd_member #(.W(CNT_W), .SH(IV_RAMP_SH)) u_ivMember (
    .x(avgQ), .edgeLo(ivEdgeLo), .edgeHi(ivEdgeHi), .deg(ivDeg));

  fzd_member #(.W(DEPTH_W), .SH(DP_RAMP_SH)) u_dpMember (
    .x(depthQ), .edgeLo(dpEdgeLo), .edgeHi(dpEdgeHi), .deg(dpDeg));

  // rule firing
  logic [RULES-1:0][DEG_W-1:0] strength;

  for (genvar i = 0; i < SETS; i++) begin : g_iv
    for (genvar j = 0; j < SETS; j++) begin : g_dp
      assign strength[i*SETS+j] = (ivDeg[i] < dpDeg[j]) ? ivDeg[i] : dpDeg[j];
    end
  end

  logic [SUM_W-1:0] yesSum, noSum;

  always_comb begin
    yesSum = '0;
    noSum  = '0;
    for (int r = 0; r < RULES; r++) begin
      if (ruleTbl[r]) yesSum = yesSum + SUM_W'(strength[r]);
      else            noSum  = noSum  + SUM_W'(strength[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              decYes <= 1'b0;
    else if (strobe.outLoad) decYes <= (yesSum > noSum);
    else                    decYes <= 1'b0;
  end
endmodule

// File: rtl/fuzzy_update_decider.sv
module fuzzy_update_decider #(
  parameter int PATHS      = 16,
  parameter int CNT_W      = 16,
  parameter int DEPTH_W    = 8,
  parameter int WEIGHT_K   = 4,
  parameter int IV_RAMP_SH = 4,
  parameter int DP_RAMP_SH = 2,
  localparam int PATH_W    = $clog2(PATHS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepEn,
  input  logic               visitValid,
  input  logic [PATH_W-1:0]  pathIdx,
  input  logic [DEPTH_W-1:0] depthIn,
  input  logic [CNT_W-1:0]   ivEdgeLo,
  input  logic [CNT_W-1:0]   ivEdgeHi,
  input  logic [DEPTH_W-1:0] dpEdgeLo,
  input  logic [DEPTH_W-1:0] dpEdgeHi,
  input  logic [8:0]         ruleTbl,
  output logic               decValid,
  output logic               decYes
);
  fzd_pkg::fzd_strobe_t strobe;

  fzd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .visitValid(visitValid),
    .strobe(strobe), .decValid(decValid));

  fzd_datapath #(
    .PATHS(PATHS), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W), .WEIGHT_K(WEIGHT_K),
    .IV_RAMP_SH(IV_RAMP_SH), .DP_RAMP_SH(DP_RAMP_SH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepEn(stepEn),
    .pathIdx(pathIdx), .depthIn(depthIn),
    .ivEdgeLo(ivEdgeLo), .ivEdgeHi(ivEdgeHi),
    .dpEdgeLo(dpEdgeLo), .dpEdgeHi(dpEdgeHi),
    .ruleTbl(ruleTbl), .decYes(decYes));
endmodule

// File: rtl/fzd_checker.sv
module fzd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       visitValid,
  input logic [8:0] ruleTbl,
  input logic       decValid,
  input logic       decYes
);
  // R9: a visit yields a strobe two edges later
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    visitValid |=> ##1 decValid);

  // R9: every strobe traces back to a visit two edges earlier
  a_r9_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(visitValid, 2));

  // R9: no yes without a strobe
  a_r9_yes_gated: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !decYes);

  // R10: all-zero rule table forces no
  a_r10_all_no: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(ruleTbl) == 9'h000) |-> !decYes);

  // R10: all-ones rule table forces yes
  a_r10_all_yes: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(ruleTbl) == 9'h1FF) |-> decYes);
endmodule

bind fuzzy_update_decider fzd_checker u_chk (
  .clk(clk), .rstN(rstN), .visitValid(visitValid), .ruleTbl(ruleTbl),
  .decValid(decValid), .decYes(decYes));

// File: tb/fuzzy_update_decider_tb.sv
module fuzzy_update_decider_tb;
  localparam int K      = 4;
  localparam int IV_SH  = 4;
  localparam int DP_SH  = 2;
  localparam int NVEC   = 10;

  // stimulus / expected vectors: path, gap before visit, depth, expected decision
  localparam int VPATH [NVEC] = '{0, 0, 0, 1, 2, 2, 2, 3, 0, 0};
  localparam int VGAP  [NVEC] = '{200, 4, 2, 3, 1, 1, 1, 1, 1, 1};
  localparam int VDEP  [NVEC] = '{20, 20, 20, 0, 5, 5, 20, 10, 3, 6};
  localparam int VEXP  [NVEC] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 1};

  logic clk = 1'b0, rstN = 1'b0, stepEn = 1'b0, visitValid = 1'b0;
  logic [3:0]  pathIdx = '0;
  logic [7:0]  depthIn = '0;
  logic [15:0] ivEdgeLo = 16'd8, ivEdgeHi = 16'd40;
  logic [7:0]  dpEdgeLo = 8'd2, dpEdgeHi = 8'd8;
  logic [8:0]  ruleTbl = 9'b000100110;
  logic decValid, decYes;

  int nChk = 0, nBad = 0;
  int mCnt = 0;
  int mLast [16];
  int mAvg  [16];

  always #2 clk = ~clk;

  fuzzy_update_decider u_dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .visitValid(visitValid),
    .pathIdx(pathIdx), .depthIn(depthIn),
    .ivEdgeLo(ivEdgeLo), .ivEdgeHi(ivEdgeHi),
    .dpEdgeLo(dpEdgeLo), .dpEdgeHi(dpEdgeHi),
    .ruleTbl(ruleTbl), .decValid(decValid), .decYes(decYes));

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rampM(int x, int s, int sh);
    int v;
    if (x < s) return 0;
    v = ((x - s) * 256) >>> sh;
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int minI(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // independent reference decision from the requirements
  function automatic int modelDecide(int avg, int dep);
    int iv [3];
    int dp [3];
    int ys, ns, st;
    iv[0] = 255 - rampM(avg, ivEdgeLo, IV_SH);
    iv[1] = minI(rampM(avg, ivEdgeLo, IV_SH), 255 - rampM(avg, ivEdgeHi, IV_SH));
    iv[2] = rampM(avg, ivEdgeHi, IV_SH);
    dp[0] = 255 - rampM(dep, dpEdgeLo, DP_SH);
    dp[1] = minI(rampM(dep, dpEdgeLo, DP_SH), 255 - rampM(dep, dpEdgeHi, DP_SH));
    dp[2] = rampM(dep, dpEdgeHi, DP_SH);
    ys = 0; ns = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        st = minI(iv[i], dp[j]);
        if (ruleTbl[i*3+j]) ys += st; else ns += st;
      end
    return (ys > ns) ? 1 : 0;
  endfunction

  function automatic int modelVisit(int p, int dep);
    int gap;
    gap = (mCnt - mLast[p]) & 16'hFFFF;
    mAvg[p]  = (mAvg[p] * K + gap * (8 - K)) >>> 3;
    mLast[p] = mCnt;
    return modelDecide(mAvg[p], dep);
  endfunction

  task automatic modelReset();
    mCnt = 0;
    for (int p = 0; p < 16; p++) begin mLast[p] = 0; mAvg[p] = 0; end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    modelReset();
  endtask

  task automatic steps(input int n);
    if (n > 0) begin
      @(negedge clk); stepEn = 1'b1;
      repeat (n) @(posedge clk);
      #1 stepEn = 1'b0;
      mCnt = (mCnt + n) & 16'hFFFF;
    end
  endtask

  // drives one visit; returns the observed decision after checking its timing (R9)
  task automatic visit(input int p, input int dep, output int got);
    @(negedge clk);
    visitValid = 1'b1; pathIdx = 4'(p); depthIn = 8'(dep);
    @(posedge clk);
    @(negedge clk); visitValid = 1'b0;
    check("R9 no strobe one edge after visit", int'(decValid), 0);
    @(posedge clk); #1;
    check("R9 strobe two edges after visit", int'(decValid), 1);
    got = int'(decYes);
    @(posedge clk); #1;
    check("R9 strobe lasts one cycle", int'(decValid), 0);
    check("R9 yes low without strobe", int'(decYes), 0);
  endtask

  initial begin
    #(4 * 190000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int got, exp;
    modelReset();
    repeat (2) @(posedge clk); #1;
    // R1: reset state
    check("R1 decValid in reset", int'(decValid), 0);
    check("R1 decYes in reset", int'(decYes), 0);
    doReset();

    // table walk: R3 average, R4 path isolation, R5/R6 grading, R7 rule bits
    for (int v = 0; v < NVEC; v++) begin
      steps(VGAP[v]);
      exp = modelVisit(VPATH[v], VDEP[v]);
      visit(VPATH[v], VDEP[v], got);
      check($sformatf("R3/R4/R5/R6/R7 vector %0d", v), got, VEXP[v]);
      check($sformatf("R8 vector %0d model", v), got, exp);
    end

    // R10: all-zero rule table
    ruleTbl = 9'h000;
    steps(1);
    exp = modelVisit(0, 6);
    visit(0, 6, got);
    check("R10 all-no table", got, 0);

    // R10: all-ones rule table
    ruleTbl = 9'h1FF;
    steps(50);
    exp = modelVisit(5, 0);
    visit(5, 0, got);
    check("R10 all-yes table", got, 1);

    // R1/R2: fresh reset, counter wrap with short gaps on one path
    ruleTbl = 9'b000100110;
    doReset();
    steps(65530);
    for (int n = 0; n < 16; n++) begin
      exp = modelVisit(4, 20);
      visit(4, 20, got);
      check($sformatf("R2 wrap visit %0d", n), got, exp);
      steps(1);
    end
    check("R2 last wrap visit decides yes", got, 1);

    // R4: another path untouched by the wrap sequence still sees the full count
    exp = modelVisit(7, 20);
    visit(7, 20, got);
    check("R4 untouched path", got, exp);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule